// File: doc/BRIEF.md
# Reset-Triggered Byte-Wide Boot Loader

This block fills internal memory with a program image held in an external byte-wide read-only memory. It needs no processor and no command. When reset is released it enables the external memory, reads consecutive bytes from byte address zero, and packs every four bytes into one 32-bit word. It writes each word through a simple internal write port and then moves on to the next word address. The length of the image in words and the internal base address are fixed by parameters.

Each external byte read uses a fixed wait window of 16 counted cycles, so a slow memory needs no handshake. Chip select and output enable are active only while the image is being copied. Once the last word has been written, the loader releases the external memory and raises a done flag that holds until the next reset. A reset asserted in the middle of a copy aborts it, and the following release starts the copy again from the beginning.

Top module: `byte_rom_boot`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rom_cs_n_o` and `rom_oe_n_o` are 1, `mem_we_o` and `boot_done_o` are 0, and `rom_addr_o` is 0.
- R2: Call the first rising edge with `rst_n` high edge 0. From edge 0 on, chip select and output enable are low (active), and no other input is needed for this.
- R3: Byte address 0 is held through edge 16, which is one set-up cycle plus 16 wait cycles. Each later byte address is held for exactly 16 cycles. The address rises by one at edge 17+16k, when byte k is sampled from `rom_data_i`.
- R4: Word j carries byte 4j in bits 7:0, byte 4j+1 in bits 15:8, byte 4j+2 in bits 23:16 and byte 4j+3 in bits 31:24 (little-endian).
- R5: Every write strobe lasts one cycle. Write j presents `mem_addr_o` = BASE_ADDR + j.
- R6: Exactly BOOT_WORDS writes occur. Write j is high in the cycle after edge 65+64j.
- R7: Chip select and output enable go inactive at edge 64·BOOT_WORDS+1, and `boot_done_o` rises at the next edge. After that, `boot_done_o` stays high until reset, with no further writes and no change of `rom_addr_o`.
- R8: A reset during a copy aborts it. On the following release the copy restarts from byte address 0 and BASE_ADDR.
- R9: Output enable always equals chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; its release starts the copy |
| rom_addr_o | output | 24 | Byte address to external memory |
| rom_cs_n_o | output | 1 | External chip select, active low |
| rom_oe_n_o | output | 1 | External output enable, active low |
| rom_data_i | input | 8 | Byte returned by external memory |
| mem_addr_o | output | MEM_AW | Internal word write address |
| mem_wdata_o | output | WORD_W | Packed word to internal memory |
| mem_we_o | output | 1 | One-cycle internal write strobe |
| boot_done_o | output | 1 | Copy finished, held until reset |

## Verification
The memory model returns a different byte for every address, and two such image patterns are used: an arithmetic ramp mixed with its upper bits, and a descending stride. Because every byte differs, a swapped lane, a shifted word or an address sampled one cycle early shows up as a wrong word. The two patterns also set apart a loader that latches stale data from one that samples on the right cycle. Every cycle is compared with the schedule derived from edge 0. A third scenario cuts a copy short with reset and then boots the second pattern in full, which separates a true restart from one that resumes where it stopped.

// File: rtl/boot_pkg.sv
// Shared types for the byte-wide boot loader.
package boot_pkg;

    // Phases of the external byte reader.
    typedef enum logic [1:0] {
        RD_LAUNCH = 2'd0,   // reset just released, memory still idle
        RD_SETUP  = 2'd1,   // select active, wait count not yet started
        RD_WAIT   = 2'd2,   // counting the wait window of one byte
        RD_HALT   = 2'd3    // image complete, memory released
    } rd_state_e;

endpackage

// File: rtl/rom_byte_reader.sv
// Sequences byte reads from the external memory.
// Assumes: the memory returns valid data within WAIT_CYCLES cycles of a
// stable address with select and output enable active; the total image
// of TOTAL_BYTES bytes fits in ROM_AW address bits.
module rom_byte_reader
    import boot_pkg::*;
#(
    parameter int ROM_AW      = 24,
    parameter int WAIT_CYCLES = 16,
    parameter int TOTAL_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ROM_AW-1:0] rom_addr_o,
    output logic              rom_cs_n_o,
    output logic              rom_oe_n_o,
    output logic              byte_vld_o
);

    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(WAIT_CYCLES);
    localparam logic [CNT_W-1:0]  CNT_FIRST = CNT_W'(1);
    localparam logic [ROM_AW-1:0] ADDR_LAST = ROM_AW'(TOTAL_BYTES - 1);

    rd_state_e          state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [ROM_AW-1:0]  addr_q;
    logic               sel_n_q;
    logic               sample;

    // Data is taken on the cycle the wait count reaches its limit.
    assign sample = (state_q == RD_WAIT) && (cnt_q == CNT_LAST);

    // Phase, wait count, byte address and select register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_LAUNCH;
            cnt_q   <= '0;
            addr_q  <= '0;
            sel_n_q <= 1'b1;
        end else begin
            case (state_q)
                RD_LAUNCH: begin
                    state_q <= RD_SETUP;
                    sel_n_q <= 1'b0;
                end
                RD_SETUP: begin
                    state_q <= RD_WAIT;
                    cnt_q   <= CNT_FIRST;
                end
                RD_WAIT: begin
                    if (sample) begin
                        addr_q <= addr_q + 1'b1;
                        cnt_q  <= CNT_FIRST;
                        if (addr_q == ADDR_LAST) begin
                            state_q <= RD_HALT;
                            sel_n_q <= 1'b1;
                            cnt_q   <= '0;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= RD_HALT;
                end
            endcase
        end
    end

    assign rom_addr_o = addr_q;
    assign rom_cs_n_o = sel_n_q;
    assign rom_oe_n_o = sel_n_q;
    assign byte_vld_o = sample;

    // Address must not move while a byte is still inside its wait window.
    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_WAIT && cnt_q != CNT_LAST) |=> $stable(addr_q));

    // Every sample advances the byte address by exactly one.
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> (addr_q == ROM_AW'($past(addr_q) + 1'b1)));

    // Select is active in every counting phase.
    assert_sel_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_SETUP || state_q == RD_WAIT) |-> !sel_n_q);

    // Once halted, the memory stays released.
    assert_halt_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_HALT) |=> (sel_n_q && $stable(addr_q)));

endmodule

// File: rtl/word_packer.sv
// Packs consecutive bytes little-endian into words and issues one write
// per full word to the internal memory port.
// Assumes: byte_vld_i is a single-cycle pulse with byte_i valid alongside.
module word_packer #(
    parameter int WORD_W    = 32,
    parameter int MEM_AW    = 16,
    parameter int BASE_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic              mem_we_o
);

    localparam int LANES   = WORD_W / 8;
    localparam int IDX_W   = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(LANES - 1);
    localparam logic [MEM_AW-1:0] ADDR_INIT = MEM_AW'(BASE_ADDR);

    logic [IDX_W-1:0]  idx_q;
    logic [7:0]        lane_q [LANES-1];
    logic [WORD_W-1:0] word_d;
    logic [MEM_AW-1:0] waddr_q;
    logic              full;

    assign full = byte_vld_i && (idx_q == IDX_LAST);

    // Lane position of the next incoming byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (byte_vld_i) begin
            idx_q <= full ? '0 : idx_q + 1'b1;
        end
    end

    // One holding register per lane except the last, which goes straight out.
    for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
        // Capture a byte when it belongs to this lane.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q[g] <= '0;
            end else if (byte_vld_i && idx_q == IDX_W'(g)) begin
                lane_q[g] <= byte_i;
            end
        end
        assign word_d[g*8 +: 8] = lane_q[g];
    end
    assign word_d[WORD_W-8 +: 8] = byte_i;

    // Write strobe, data and word address toward internal memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we_o    <= 1'b0;
            mem_wdata_o <= '0;
            mem_addr_o  <= ADDR_INIT;
            waddr_q     <= ADDR_INIT;
        end else begin
            mem_we_o <= full;
            if (full) begin
                mem_wdata_o <= word_d;
                mem_addr_o  <= waddr_q;
                waddr_q     <= waddr_q + 1'b1;
            end
        end
    end

    // A write strobe never lasts more than one cycle.
    assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

    // The address presented by a write is the one before the next slot.
    assert_waddr_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (waddr_q == MEM_AW'(mem_addr_o + 1'b1)));

endmodule

// File: rtl/boot_done_tracker.sv
// Counts completed word writes and raises a sticky done flag after the
// last one. Assumes mem_we_i pulses once per word.
module boot_done_tracker #(
    parameter int BOOT_WORDS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mem_we_i,
    input  logic rom_cs_n_i,
    output logic boot_done_o
);

    localparam int CW = $clog2(BOOT_WORDS + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(BOOT_WORDS - 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(BOOT_WORDS);

    logic [CW-1:0] wcnt_q;

    // Written-word count and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q      <= '0;
            boot_done_o <= 1'b0;
        end else if (mem_we_i) begin
            wcnt_q <= wcnt_q + 1'b1;
            if (wcnt_q == CNT_LAST) begin
                boot_done_o <= 1'b1;
            end
        end
    end

    // No write is issued beyond the image length.
    assert_no_extra_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wcnt_q == CNT_MAX) |-> !mem_we_i);

    // Done is sticky until reset.
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done_o |=> boot_done_o);

    // External memory is released whenever done is shown.
    assert_done_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done_o |-> rom_cs_n_i);

endmodule

// File: rtl/byte_rom_boot.sv
// Top of the reset-triggered boot loader: reads a byte-wide external
// memory after reset, packs words and writes them to internal memory.
// Assumes: BOOT_WORDS*WORD_W/8 bytes fit in ROM_AW address bits and
// WORD_W is a multiple of 8.
module byte_rom_boot #(
    parameter int ROM_AW      = 24,
    parameter int WAIT_CYCLES = 16,
    parameter int WORD_W      = 32,
    parameter int MEM_AW      = 16,
    parameter int BOOT_WORDS  = 8,
    parameter int BASE_ADDR   = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ROM_AW-1:0] rom_addr_o,
    output logic              rom_cs_n_o,
    output logic              rom_oe_n_o,
    input  logic [7:0]        rom_data_i,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              boot_done_o
);

    localparam int TOTAL_BYTES = BOOT_WORDS * (WORD_W / 8);

    logic byte_vld;

    rom_byte_reader #(
        .ROM_AW      (ROM_AW),
        .WAIT_CYCLES (WAIT_CYCLES),
        .TOTAL_BYTES (TOTAL_BYTES)
    ) u_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .rom_addr_o (rom_addr_o),
        .rom_cs_n_o (rom_cs_n_o),
        .rom_oe_n_o (rom_oe_n_o),
        .byte_vld_o (byte_vld)
    );

    word_packer #(
        .WORD_W    (WORD_W),
        .MEM_AW    (MEM_AW),
        .BASE_ADDR (BASE_ADDR)
    ) u_packer (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_vld_i  (byte_vld),
        .byte_i      (rom_data_i),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_we_o    (mem_we_o)
    );

    boot_done_tracker #(
        .BOOT_WORDS (BOOT_WORDS)
    ) u_done (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_we_i    (mem_we_o),
        .rom_cs_n_i  (rom_cs_n_o),
        .boot_done_o (boot_done_o)
    );

    // Output enable follows chip select at all times.
    always_comb begin
        assert_oe_tracks_cs_R9: assert (rom_oe_n_o == rom_cs_n_o);
    end

    // Memory is idle in the cycle after a reset edge.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (rom_cs_n_o && !mem_we_o && !boot_done_o));

endmodule

// File: tb/test_byte_rom_boot.sv
// Directed bench for the boot loader: one task per scenario.
module test_byte_rom_boot;

    localparam int W    = 6;
    localparam int BASE = 'h40;
    localparam int AW   = 16;
    localparam int LAST_EDGE = 64 * W + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [23:0]    rom_addr;
    logic           rom_cs_n, rom_oe_n;
    logic [7:0]     rom_data;
    logic [AW-1:0]  mem_addr;
    logic [31:0]    mem_wdata;
    logic           mem_we, boot_done;

    int checks = 0;
    int fails  = 0;
    int edge_n = -1;
    int pattern = 0;

    always #2 clk = ~clk;

    byte_rom_boot #(
        .BOOT_WORDS (W),
        .BASE_ADDR  (BASE),
        .MEM_AW     (AW)
    ) i_byte_rom_boot (
        .clk         (clk),
        .rst_n       (rst_n),
        .rom_addr_o  (rom_addr),
        .rom_cs_n_o  (rom_cs_n),
        .rom_oe_n_o  (rom_oe_n),
        .rom_data_i  (rom_data),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_we_o    (mem_we),
        .boot_done_o (boot_done)
    );

    // Image content: every address gives a different byte.
    function automatic logic [7:0] rom_byte(input int a, input int pat);
        if (pat == 0) return 8'((a * 7 + 3) ^ (a >> 3));
        return 8'(8'hFF - a * 13);
    endfunction

    always_comb rom_data = rom_byte(int'(rom_addr), pattern);

    // Index of the latest edge since reset release (edge 0 is the first).
    always @(posedge clk) begin
        if (!rst_n) edge_n <= -1;
        else        edge_n <= edge_n + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reset, check R1, release; then compare every cycle with the schedule.
    task automatic run_boot(input int pat, input int n_cyc,
                            output int n_wr, output int first_addr);
        n_wr = 0;
        first_addr = -1;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rom_cs_n == 1'b1, "R1", "cs_n in reset", rom_cs_n, 1);
        chk(rom_oe_n == 1'b1, "R1", "oe_n in reset", rom_oe_n, 1);
        chk(mem_we == 1'b0, "R1", "we in reset", mem_we, 0);
        chk(boot_done == 1'b0, "R1", "done in reset", boot_done, 0);
        chk(rom_addr == 24'd0, "R1", "addr in reset", rom_addr, 0);
        pattern = pat;
        rst_n = 1'b1;
        for (int i = 0; i < n_cyc; i++) begin
            int e, exp_addr, j;
            bit exp_sel, exp_we, exp_done;
            @(negedge clk);
            e = edge_n;
            exp_sel  = (e >= 0) && (e < LAST_EDGE);
            exp_done = (e >= LAST_EDGE + 1);
            exp_addr = (e < 17) ? 0 : ((e - 17) / 16 + 1);
            if (exp_addr > 4 * W) exp_addr = 4 * W;
            j = (e - 65) / 64;
            exp_we = (e >= 65) && ((e - 65) % 64 == 0) && (j < W);
            chk(rom_cs_n == !exp_sel, (e < LAST_EDGE) ? "R2" : "R7", "cs_n", rom_cs_n, !exp_sel);
            chk(rom_oe_n == rom_cs_n, "R9", "oe_n vs cs_n", rom_oe_n, rom_cs_n);
            chk(int'(rom_addr) == exp_addr, "R3", "byte address", rom_addr, exp_addr);
            chk(mem_we == exp_we, "R6", "write strobe", mem_we, exp_we);
            chk(boot_done == exp_done, "R7", "done", boot_done, exp_done);
            if (mem_we) begin
                logic [31:0] exp_w;
                for (int b = 0; b < 4; b++)
                    exp_w[b*8 +: 8] = rom_byte(4 * n_wr + b, pat);
                if (first_addr < 0) first_addr = int'(mem_addr);
                chk(int'(mem_addr) == BASE + n_wr, "R5", "word address", mem_addr, BASE + n_wr);
                chk(mem_wdata == exp_w, "R4", "packed word", mem_wdata, exp_w);
                n_wr++;
            end
        end
    endtask

    task automatic scenario_ramp();
        int n, fa;
        run_boot(0, LAST_EDGE + 60, n, fa);
        chk(n == W, "R6", "write count ramp", n, W);
    endtask

    task automatic scenario_stride();
        int n, fa;
        run_boot(1, LAST_EDGE + 60, n, fa);
        chk(n == W, "R6", "write count stride", n, W);
    endtask

    task automatic scenario_abort();
        int n, fa;
        run_boot(0, 150, n, fa);
        chk(n == 2, "R8", "writes before abort", n, 2);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(rom_addr == 24'd0, "R8", "addr after abort", rom_addr, 0);
        chk(rom_cs_n == 1'b1, "R8", "cs_n after abort", rom_cs_n, 1);
        run_boot(1, LAST_EDGE + 20, n, fa);
        chk(n == W, "R8", "write count after restart", n, W);
        chk(fa == BASE, "R8", "first address after restart", fa, BASE);
    endtask

    initial begin
        scenario_ramp();
        scenario_stride();
        scenario_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule